// File: doc/BRIEF.md
# User Bit Capture Buffer with Indirect Host Access

This block collects the user bit carried in each subframe of an incoming digital audio interface stream and packs it into a byte buffer. A host reads the buffer through a pair of registers instead of a flat memory window. One register holds a byte offset. The other returns the byte at that offset, and every read of it moves the offset on by one byte. To read a whole block the host writes offset zero and then reads the data register repeatedly.

Capture uses two storage levels. A fill buffer collects bits as the subframes arrive. When it has a complete set, the whole set is copied in one step to the buffer the host reads, and a ready flag is raised. The host therefore never sees a mix of two blocks. A size input sets the capture length. In narrow mode only channel A bits are kept, giving 24 bytes per 192-frame block. In wide mode the channel A and channel B bits are kept interleaved frame by frame, giving 48 bytes.

Top module: `user_bit_buffer`

## Requirements
- R1: After reset the ready flag is 0, the offset is 0, and the data register (address 0x51) reads 0.
- R2: A write to the offset register (address 0x50) with a value inside the selected size loads that value, and a read of address 0x50 returns the current offset.
- R3: A read of address 0x51 returns the byte at the current offset. Bit k of byte n is captured bit 8n+k, so bits are packed LSB first.
- R4: Each read of address 0x51 moves the offset to the next byte.
- R5: A read of address 0x51 when the offset is at or beyond the last byte of the selected size (23 in narrow mode, 47 in wide mode) sets the offset to 0.
- R6: An offset write above the last byte of the selected size loads the last byte instead.
- R7: In narrow mode (size_sel = 0), subframes marked as channel B are ignored. Captured bit f is the channel A bit of frame f, for f from 0 to 191.
- R8: In wide mode (size_sel = 1), captured bit 2f is the channel A bit of frame f and captured bit 2f+1 is the channel B bit of frame f, for 48 bytes in total.
- R9: The readable buffer does not change while a block is filling. It is replaced as a whole, and the ready flag rises, on the clock edge that follows the edge which captured the final bit.
- R10: A write to the offset register clears the ready flag, unless a transfer sets the flag in the same cycle.
- R11: Capture begins only on a channel A subframe flagged as block start. A block start that arrives in the middle of a fill discards the partial fill and restarts at bit 0.
- R12: A read of address 0x50 or of any other address leaves the offset unchanged. Addresses other than 0x50 and 0x51 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ub_valid | input | 1 | One subframe's user bit is present this cycle |
| ub_bit | input | 1 | User bit value |
| ub_chan_b | input | 1 | 1 when the subframe belongs to channel B |
| ub_block_start | input | 1 | Subframe is the first of a 192-frame block |
| size_sel | input | 1 | 0 selects 24-byte channel A capture, 1 selects 48-byte interleaved capture |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe |
| reg_addr | input | AW | Host register address |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data for the addressed register (combinational) |
| buf_ready | output | 1 | A fresh block has been transferred since the last offset write |

## Verification
If the offset pointer were wrong, the next data read would return a byte that differs from the one the host expects. Pointer wrap and clamp faults appear on the very read that crosses the last byte, or on a read-back of address 0x50 right after the write. If the fill counter or its sync state were wrong, every byte after the faulty bit would differ, or the ready flag would rise at the wrong cycle. The bench checks the ready flag on the exact cycle after the final captured bit. A transfer that leaked a partial fill would show old or mixed bytes on reads made while the next block is arriving.

// File: rtl/ubuf_pkg.sv
package ubuf_pkg;

  typedef enum logic [1:0] {
    HOST_NONE = 2'd0,
    HOST_IDX  = 2'd1,
    HOST_DAT  = 2'd2
  } host_sel_e;

  // index of the final captured bit for the chosen size
  function automatic int unsigned last_bit_f(logic wide, int unsigned frames);
    return wide ? (2 * frames - 1) : (frames - 1);
  endfunction

  // index of the final readable byte for the chosen size
  function automatic int unsigned last_byte_f(logic wide, int unsigned bytes_one);
    return wide ? (2 * bytes_one - 1) : (bytes_one - 1);
  endfunction

  // host offset write limited to the last valid byte
  function automatic int unsigned clamp_f(int unsigned req, int unsigned last);
    return (req > last) ? last : req;
  endfunction

  // offset after one data read, wrapping past the last byte
  function automatic int unsigned next_f(int unsigned cur, int unsigned last);
    return (cur >= last) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/ubuf_capture.sv
module ubuf_capture #(
  parameter int FRAMES   = 192,
  parameter int BITS_MAX = 384,
  parameter int IDXW     = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ub_valid,
  input  logic                ub_bit,
  input  logic                ub_chan_b,
  input  logic                ub_block_start,
  input  logic                size_sel,
  output logic [BITS_MAX-1:0] shadow_bits,
  output logic [IDXW-1:0]     bit_idx,
  output logic                cap_evt,
  output logic                fill_done
);
  import ubuf_pkg::*;

  localparam int NBYTES = BITS_MAX / 8;

  logic            synced;
  logic            start_evt;
  logic            take;
  logic            done_now;
  logic [IDXW-1:0] wr_idx;
  logic [IDXW-1:0] last_bit;

  assign last_bit  = IDXW'(last_bit_f(size_sel, FRAMES));
  assign start_evt = ub_valid & ~ub_chan_b & ub_block_start;
  assign take      = ub_valid & (~ub_chan_b | size_sel);
  assign cap_evt   = start_evt | (take & synced);
  assign wr_idx    = start_evt ? '0 : bit_idx;
  assign done_now  = cap_evt & (wr_idx >= last_bit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_idx   <= '0;
      synced    <= 1'b0;
      fill_done <= 1'b0;
    end else begin
      fill_done <= done_now;
      if (cap_evt) begin
        if (done_now) begin
          bit_idx <= '0;
          synced  <= 1'b0;
        end else begin
          bit_idx <= wr_idx + 1'b1;
          synced  <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        byte_q <= '0;
      end else if (cap_evt && (wr_idx[IDXW-1:3] == (IDXW-3)'(g))) begin
        byte_q[wr_idx[2:0]] <= ub_bit;
      end
    end
    assign shadow_bits[g*8 +: 8] = byte_q;
  end

endmodule

// File: rtl/ubuf_hold.sv
module ubuf_hold #(
  parameter int BITS_MAX = 384
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                clear_ready,
  input  logic [BITS_MAX-1:0] shadow_bits,
  output logic [BITS_MAX-1:0] hold_bits,
  output logic                ready
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_bits <= '0;
      ready     <= 1'b0;
    end else begin
      if (load) begin
        hold_bits <= shadow_bits;
      end
      if (load) begin
        ready <= 1'b1;
      end else if (clear_ready) begin
        ready <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ubuf_host.sv
module ubuf_host #(
  parameter int            AW        = 8,
  parameter int            PTRW      = 6,
  parameter int            BYTES_ONE = 24,
  parameter int            BITS_MAX  = 384,
  parameter logic [AW-1:0] IDX_REG   = 'h50,
  parameter logic [AW-1:0] DAT_REG   = 'h51
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                size_sel,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [AW-1:0]       reg_addr,
  input  logic [7:0]          reg_wdata,
  input  logic [BITS_MAX-1:0] hold_bits,
  output logic [7:0]          reg_rdata,
  output logic [PTRW-1:0]     ptr,
  output logic [PTRW-1:0]     last_byte,
  output logic                wr_idx_evt,
  output logic                rd_dat_evt
);
  import ubuf_pkg::*;

  host_sel_e sel;

  always_comb begin
    sel = HOST_NONE;
    if (reg_addr == IDX_REG) begin
      sel = HOST_IDX;
    end else if (reg_addr == DAT_REG) begin
      sel = HOST_DAT;
    end
  end

  assign last_byte  = PTRW'(last_byte_f(size_sel, BYTES_ONE));
  assign wr_idx_evt = reg_wr & (sel == HOST_IDX);
  assign rd_dat_evt = reg_rd & ~reg_wr & (sel == HOST_DAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (wr_idx_evt) begin
      ptr <= PTRW'(clamp_f(32'(reg_wdata), 32'(last_byte)));
    end else if (rd_dat_evt) begin
      ptr <= PTRW'(next_f(32'(ptr), 32'(last_byte)));
    end
  end

  always_comb begin
    unique case (sel)
      HOST_IDX: reg_rdata = 8'(ptr);
      HOST_DAT: reg_rdata = hold_bits[{ptr, 3'b000} +: 8];
      default:  reg_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/user_bit_buffer.sv
module user_bit_buffer #(
  parameter int            FRAMES  = 192,
  parameter int            AW      = 8,
  parameter logic [AW-1:0] IDX_REG = 'h50,
  parameter logic [AW-1:0] DAT_REG = 'h51
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ub_valid,
  input  logic          ub_bit,
  input  logic          ub_chan_b,
  input  logic          ub_block_start,
  input  logic          size_sel,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          buf_ready
);

  localparam int BYTES_ONE = FRAMES / 8;
  localparam int BITS_MAX  = 2 * FRAMES;
  localparam int BYTES_MAX = 2 * BYTES_ONE;
  localparam int IDXW      = $clog2(BITS_MAX);
  localparam int PTRW      = $clog2(BYTES_MAX);

  // named internal events, visible to the bound checker
  logic [BITS_MAX-1:0] shadow_bits;
  logic [BITS_MAX-1:0] hold_bits;
  logic [IDXW-1:0]     bit_idx;
  logic                cap_evt;
  logic                fill_done;
  logic [PTRW-1:0]     ptr;
  logic [PTRW-1:0]     last_byte;
  logic                wr_idx_evt;
  logic                rd_dat_evt;

  ubuf_capture #(
    .FRAMES   (FRAMES),
    .BITS_MAX (BITS_MAX),
    .IDXW     (IDXW)
  ) i_capture (
    .clk            (clk),
    .rst_n          (rst_n),
    .ub_valid       (ub_valid),
    .ub_bit         (ub_bit),
    .ub_chan_b      (ub_chan_b),
    .ub_block_start (ub_block_start),
    .size_sel       (size_sel),
    .shadow_bits    (shadow_bits),
    .bit_idx        (bit_idx),
    .cap_evt        (cap_evt),
    .fill_done      (fill_done)
  );

  ubuf_hold #(
    .BITS_MAX (BITS_MAX)
  ) i_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (fill_done),
    .clear_ready (wr_idx_evt),
    .shadow_bits (shadow_bits),
    .hold_bits   (hold_bits),
    .ready       (buf_ready)
  );

  ubuf_host #(
    .AW        (AW),
    .PTRW      (PTRW),
    .BYTES_ONE (BYTES_ONE),
    .BITS_MAX  (BITS_MAX),
    .IDX_REG   (IDX_REG),
    .DAT_REG   (DAT_REG)
  ) i_host (
    .clk        (clk),
    .rst_n      (rst_n),
    .size_sel   (size_sel),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .hold_bits  (hold_bits),
    .reg_rdata  (reg_rdata),
    .ptr        (ptr),
    .last_byte  (last_byte),
    .wr_idx_evt (wr_idx_evt),
    .rd_dat_evt (rd_dat_evt)
  );

endmodule

// File: rtl/user_bit_buffer_chk.sv
module user_bit_buffer_chk #(
  parameter int            AW       = 8,
  parameter int            PTRW     = 6,
  parameter int            IDXW     = 9,
  parameter int            BITS_MAX = 384,
  parameter logic [AW-1:0] IDX_REG  = 'h50
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ub_valid,
  input logic                ub_chan_b,
  input logic                ub_block_start,
  input logic                size_sel,
  input logic                reg_wr,
  input logic                reg_rd,
  input logic [AW-1:0]       reg_addr,
  input logic [7:0]          reg_wdata,
  input logic                buf_ready,
  input logic [BITS_MAX-1:0] hold_bits,
  input logic [IDXW-1:0]     bit_idx,
  input logic                fill_done,
  input logic [PTRW-1:0]     ptr,
  input logic [PTRW-1:0]     last_byte,
  input logic                wr_idx_evt,
  input logic                rd_dat_evt
);

  // R2
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idx_evt && (reg_wdata <= 8'(last_byte)) |=> 8'(ptr) == $past(reg_wdata));

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_dat_evt && (ptr < last_byte) |=> ptr == $past(ptr) + 1'b1);

  // R5
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_dat_evt && (ptr >= last_byte) |=> ptr == '0);

  // R6
  idx_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idx_evt && (reg_wdata > 8'(last_byte)) |=> ptr == $past(last_byte));

  // R12
  idx_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && !reg_wr && (reg_addr == IDX_REG) |=> $stable(ptr));

  // R9
  load_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> buf_ready);

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_done |=> $stable(hold_bits));

  // R10
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idx_evt && !fill_done |=> !buf_ready);

  // R7
  b_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ub_valid && ub_chan_b && !size_sel |=> $stable(bit_idx));

  // R11
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ub_valid && !ub_chan_b && ub_block_start |=> bit_idx == IDXW'(1));

endmodule

bind user_bit_buffer user_bit_buffer_chk #(
  .AW       (AW),
  .PTRW     (PTRW),
  .IDXW     (IDXW),
  .BITS_MAX (BITS_MAX),
  .IDX_REG  (IDX_REG)
) i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ub_valid       (ub_valid),
  .ub_chan_b      (ub_chan_b),
  .ub_block_start (ub_block_start),
  .size_sel       (size_sel),
  .reg_wr         (reg_wr),
  .reg_rd         (reg_rd),
  .reg_addr       (reg_addr),
  .reg_wdata      (reg_wdata),
  .buf_ready      (buf_ready),
  .hold_bits      (hold_bits),
  .bit_idx        (bit_idx),
  .fill_done      (fill_done),
  .ptr            (ptr),
  .last_byte      (last_byte),
  .wr_idx_evt     (wr_idx_evt),
  .rd_dat_evt     (rd_dat_evt)
);

// File: tb/test_user_bit_buffer.sv
`timescale 1ns/1ps
module test_user_bit_buffer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ub_valid = 1'b0;
  logic       ub_bit = 1'b0;
  logic       ub_chan_b = 1'b0;
  logic       ub_block_start = 1'b0;
  logic       size_sel = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       buf_ready;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  user_bit_buffer i_user_bit_buffer (
    .clk(clk), .rst_n(rst_n), .ub_valid(ub_valid), .ub_bit(ub_bit),
    .ub_chan_b(ub_chan_b), .ub_block_start(ub_block_start), .size_sel(size_sel),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .buf_ready(buf_ready)
  );

  // kind: 0 = offset write of val, 1 = data read expecting captured byte val,
  //       2 = read expecting literal val
  typedef struct packed {
    logic [1:0] kind;
    logic [7:0] addr;
    logic [7:0] val;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 8'h50, 8'd0,   4'd2},   // R2 load offset 0
    '{2'd1, 8'h51, 8'd0,   4'd3},   // R3 byte 0
    '{2'd1, 8'h51, 8'd1,   4'd4},   // R4 advanced to byte 1
    '{2'd2, 8'h50, 8'd2,   4'd4},   // R4 offset now 2
    '{2'd1, 8'h51, 8'd2,   4'd3},   // R3 byte 2
    '{2'd0, 8'h50, 8'd22,  4'd2},   // R2 load 22
    '{2'd2, 8'h50, 8'd22,  4'd2},   // R2 read back
    '{2'd1, 8'h51, 8'd22,  4'd3},   // R3 byte 22
    '{2'd1, 8'h51, 8'd23,  4'd5},   // R5 last byte
    '{2'd1, 8'h51, 8'd0,   4'd5},   // R5 wrapped to 0
    '{2'd0, 8'h50, 8'd200, 4'd6},   // R6 out of range
    '{2'd2, 8'h50, 8'd23,  4'd6},   // R6 clamped to 23
    '{2'd1, 8'h51, 8'd23,  4'd6},   // R6 byte 23
    '{2'd2, 8'h50, 8'd0,   4'd5},   // R5 wrapped after 23
    '{2'd2, 8'h50, 8'd0,   4'd12},  // R12 offset read does not advance
    '{2'd2, 8'h33, 8'd0,   4'd12},  // R12 unmapped reads zero
    '{2'd1, 8'h51, 8'd0,   4'd12}   // R12 still at byte 0
  };

  function automatic logic pat(int seed, int f, int ch);
    return logic'(((f * 13 + seed * 7 + ch * 5 + (f / 9)) % 9) < 4);
  endfunction

  // expected byte n: bit k is captured bit 8n+k (R3, R7, R8)
  function automatic logic [7:0] exp_byte(logic wide, int seed, int n);
    logic [7:0] b;
    for (int k = 0; k < 8; k++) begin
      int i = 8 * n + k;
      b[k] = wide ? pat(seed, i / 2, i % 2) : pat(seed, i, 0);
    end
    return b;
  endfunction

  task automatic check(int req, logic [7:0] act, logic [7:0] exp, string what);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic sub(logic ch, logic b, logic s);
    @(negedge clk);
    ub_valid = 1'b1; ub_chan_b = ch; ub_bit = b; ub_block_start = s;
  endtask

  task automatic send_frames(int seed, int nframes, bit with_start);
    for (int f = 0; f < nframes; f++) begin
      sub(1'b0, pat(seed, f, 0), with_start && (f == 0));
      sub(1'b1, pat(seed, f, 1), 1'b0);
    end
  endtask

  task automatic idle(int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      ub_valid = 1'b0; ub_block_start = 1'b0;
    end
  endtask

  task automatic host_wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic host_rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk);
    #1 reg_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check(1, 8'(buf_ready), 8'd0, "ready after reset");
    host_rd(8'h50, d); check(1, d, 8'd0, "offset after reset");
    host_rd(8'h51, d); check(1, d, 8'd0, "data after reset");

    // R11 bits before any block start are dropped; a restart discards a partial fill
    send_frames(7, 10, 1'b0);
    send_frames(9, 50, 1'b1);
    // R7 narrow block with channel B subframes present
    send_frames(1, 192, 1'b1);
    idle(3);
    check(9, 8'(buf_ready), 8'd1, "ready after narrow block");

    for (int v = 0; v < NV; v++) begin
      if (VECS[v].kind == 2'd0) begin
        host_wr(VECS[v].addr, VECS[v].val);
      end else begin
        host_rd(VECS[v].addr, d);
        if (VECS[v].kind == 2'd1)
          check(int'(VECS[v].req), d, exp_byte(1'b0, 1, int'(VECS[v].val)), "vector data");
        else
          check(int'(VECS[v].req), d, VECS[v].val, "vector literal");
      end
    end
    // R10 offset writes in the table cleared ready
    check(10, 8'(buf_ready), 8'd0, "ready cleared by offset write");

    // R9 readable buffer unchanged while the next block is filling
    send_frames(4, 100, 1'b1);
    idle(1);
    host_wr(8'h50, 8'd5);
    host_rd(8'h51, d); check(9, d, exp_byte(1'b0, 1, 5), "old byte 5 during fill");
    check(9, 8'(buf_ready), 8'd0, "no ready during fill");

    // R8 wide block, R11 restarts the pending fill, R9 exact ready timing
    size_sel = 1'b1;
    send_frames(3, 192, 1'b1);
    @(negedge clk);
    ub_valid = 1'b0;
    check(9, 8'(buf_ready), 8'd0, "ready one cycle after final bit");
    @(negedge clk);
    check(9, 8'(buf_ready), 8'd1, "ready two cycles after final bit");

    host_wr(8'h50, 8'd0);
    check(10, 8'(buf_ready), 8'd0, "ready cleared in wide mode");
    for (int n = 0; n < 48; n++) begin
      host_rd(8'h51, d); check(8, d, exp_byte(1'b1, 3, n), "wide byte");
    end
    // R5 wrap at 47
    host_rd(8'h51, d); check(5, d, exp_byte(1'b1, 3, 0), "wide wrap to byte 0");
    // R6 clamp to 47 in wide mode
    host_wr(8'h50, 8'd100);
    host_rd(8'h50, d); check(6, d, 8'd47, "wide clamp");
    // R2 offset above narrow limit accepted in wide mode
    host_wr(8'h50, 8'd30);
    host_rd(8'h50, d); check(2, d, 8'd30, "wide offset load");
    host_rd(8'h51, d); check(8, d, exp_byte(1'b1, 3, 30), "wide byte 30");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule